// File: doc/BRIEF.md
# Multicycle Issue Interlock

This block sits at the decode/issue stage of an in-order pipeline whose functional units have unequal execute depths. The units are a single-stage integer/load/store unit, a pipelined four-stage FP adder, a pipelined seven-stage FP multiplier and an unpipelined divider. Each cycle the decoder presents one instruction: its unit class, up to two source registers with per-operand use flags, a destination register and a valid flag. The block decides in the same cycle whether the instruction leaves decode (`issue`) or holds there (`stall`). It also reports, for each operand, whether that operand can be forwarded in time.

Internally the block keeps three kinds of state. A countdown per register gives the cycles until the register's pending result can be forwarded, and a second countdown gives the cycles until its pending writer reaches the memory stage. A busy countdown covers the divider. A shift register books the single register write port by cycle. Every piece of state advances each cycle. Only an instruction that actually issues updates the state.

Timing convention: an instruction that issues in cycle t with E execute stages occupies the execute stages in cycles t+1..t+E. It is in the memory stage in cycle t+E+1 and in write-back in cycle t+E+2.

Top module: `fpil_issue_ctl`

## Requirements
- R1: After reset no register is pending, the divider is idle and no write slot is booked. Both ready outputs read 1, and a valid instruction issues in its first cycle.
- R2: While `id_valid` is 0, both `issue` and `stall` are 0. While `id_valid` is 1, exactly one of them is 1.
- R3: Class codes 0 (ALU) and 1 (load) take one execute stage. A consumer of an ALU result may issue one cycle after the producer, with no stall. A consumer of a load result may issue no earlier than two cycles after the load.
- R4: Class codes 3 (FP add, 4 stages), 4 (FP multiply, 7 stages) and 5 (divide, 24 stages) make their result forwardable to a consumer issuing exactly N_stages cycles after the producer, and no earlier.
- R5: `src_a_ready`/`src_b_ready` are 1 when the operand is unused or its register has no unforwardable pending result. An instruction never issues with a used operand not ready.
- R6: The divider is unpipelined. A divide issued in cycle t blocks any other divide until cycle t+26, the cycle in which the first divide is in write-back.
- R7: An instruction of any class except store (code 2) books the write-back slot of cycle t+E+2. Issue stalls while that slot is already booked. Stores never book or test a slot.
- R8: An instruction whose destination matches that of an in-flight writer issued in cycle t with E stages stalls until cycle t+E+1, when that writer is in the memory stage.
- R9: A stalled instruction books no slot, marks no register pending and does not occupy the divider. Withdrawing it leaves the state as if it had never been presented.
- R10: Independent instructions to the pipelined adder or multiplier issue in consecutive cycles when their write slots differ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode holds an instruction |
| id_cls | input | 3 | Unit class: 0 ALU, 1 load, 2 store, 3 FP add, 4 FP multiply, 5 divide |
| id_src_a | input | RW | First source register |
| id_src_a_use | input | 1 | First source is read |
| id_src_b | input | RW | Second source register |
| id_src_b_use | input | 1 | Second source is read |
| id_dst | input | RW | Destination register (ignored for stores) |
| issue | output | 1 | Instruction leaves decode this cycle |
| stall | output | 1 | Instruction holds in decode this cycle |
| src_a_ready | output | 1 | First operand can be forwarded in time |
| src_b_ready | output | 1 | Second operand can be forwarded in time |

## Verification
The bench builds the block with its defaults: 32 registers and execute depths of 1, 4, 7 and 24. At these depths a multiply followed three cycles later by an add lands in the same write-back slot. The bench also reaches the full 26-cycle divider window and the seven-cycle multiply-to-add dependency. A reference model in the bench computes the expected issue cycle of every instruction. It covers dependent load/multiply/add/store chains, back-to-back multiplies, write-slot clashes, same-destination writers and a withdrawn stalled divide.

// File: rtl/fpil_pkg.sv
package fpil_pkg;

    localparam int TW = 8;

    typedef enum logic [2:0] {
        CLS_ALU   = 3'd0,
        CLS_LOAD  = 3'd1,
        CLS_STORE = 3'd2,
        CLS_FADD  = 3'd3,
        CLS_FMUL  = 3'd4,
        CLS_FDIV  = 3'd5
    } op_cls_e;

    typedef struct packed {
        logic [TW-1:0] stages;   // execute stages
        logic [TW-1:0] fwd;      // cycles from issue until a consumer may issue
        logic [TW-1:0] wb_dist;  // cycles from issue until write-back
        logic          writes;   // books the write port
        logic          is_div;   // uses the unpipelined divider
    } op_timing_t;

    function automatic op_timing_t op_timing(
        input logic [2:0]  cls,
        input int unsigned n_int,
        input int unsigned n_add,
        input int unsigned n_mul,
        input int unsigned n_div
    );
        op_timing_t t;
        t.stages = TW'(n_int);
        t.writes = 1'b1;
        t.is_div = 1'b0;
        case (op_cls_e'(cls))
            CLS_FADD:  t.stages = TW'(n_add);
            CLS_FMUL:  t.stages = TW'(n_mul);
            CLS_FDIV:  begin t.stages = TW'(n_div); t.is_div = 1'b1; end
            CLS_STORE: t.writes = 1'b0;
            default:   ;
        endcase
        t.fwd     = (op_cls_e'(cls) == CLS_LOAD) ? t.stages + TW'(1) : t.stages;
        t.wb_dist = t.stages + TW'(2);
        return t;
    endfunction

endpackage

// File: rtl/fpil_reg_track.sv
module fpil_reg_track #(
    parameter int NREG = 32,
    parameter int RW   = 5,
    parameter int TW   = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [RW-1:0] rd_a,
    input  logic [RW-1:0] rd_b,
    input  logic [RW-1:0] dst_q,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_dst,
    input  logic [TW-1:0] wr_fwd,
    input  logic [TW-1:0] wr_mem,
    output logic          a_pend,
    output logic          b_pend,
    output logic          dst_waw
);
    logic [TW-1:0] raw_cnt [NREG];
    logic [TW-1:0] waw_cnt [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREG; r++) begin
                raw_cnt[r] <= '0;
                waw_cnt[r] <= '0;
            end
        end else begin
            for (int r = 0; r < NREG; r++) begin
                if (wr_en && wr_dst == RW'(r)) begin
                    raw_cnt[r] <= wr_fwd - TW'(1);
                    waw_cnt[r] <= wr_mem;
                end else begin
                    if (raw_cnt[r] != '0) raw_cnt[r] <= raw_cnt[r] - TW'(1);
                    if (waw_cnt[r] != '0) waw_cnt[r] <= waw_cnt[r] - TW'(1);
                end
            end
        end
    end

    assign a_pend  = raw_cnt[rd_a] != '0;
    assign b_pend  = raw_cnt[rd_b] != '0;
    assign dst_waw = waw_cnt[dst_q] != '0;

endmodule

// File: rtl/fpil_port_track.sv
module fpil_port_track #(
    parameter int WBW = 27,
    parameter int SW  = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          book_en,
    input  logic [SW-1:0] book_slot,
    output logic          slot_taken
);
    logic [WBW-1:0] resv;

    always_ff @(posedge clk) begin
        if (rst) begin
            resv <= '0;
        end else begin
            for (int k = 0; k < WBW; k++) begin
                resv[k] <= ((k + 1 < WBW) ? resv[(k + 1) % WBW] : 1'b0)
                         | (book_en && book_slot == SW'(k + 1));
            end
        end
    end

    assign slot_taken = resv[book_slot];

endmodule

// File: rtl/fpil_div_track.sv
module fpil_div_track #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [TW-1:0] span,
    output logic          busy
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (start)      cnt <= span - TW'(1);
        else if (cnt != '0)  cnt <= cnt - TW'(1);
    end

    assign busy = cnt != '0;

endmodule

// File: rtl/fpil_issue_ctl.sv
module fpil_issue_ctl
    import fpil_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int N_INT = 1,
    parameter int N_ADD = 4,
    parameter int N_MUL = 7,
    parameter int N_DIV = 24,
    localparam int RW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          id_valid,
    input  logic [2:0]    id_cls,
    input  logic [RW-1:0] id_src_a,
    input  logic          id_src_a_use,
    input  logic [RW-1:0] id_src_b,
    input  logic          id_src_b_use,
    input  logic [RW-1:0] id_dst,
    output logic          issue,
    output logic          stall,
    output logic          src_a_ready,
    output logic          src_b_ready
);
    localparam int WBW = N_DIV + 3;
    localparam int SW  = $clog2(WBW + 1);

    op_timing_t tm;
    logic a_pend, b_pend, dst_waw, slot_taken, div_busy;
    logic struct_ok, data_ok;

    assign tm = op_timing(id_cls, N_INT, N_ADD, N_MUL, N_DIV);

    fpil_reg_track #(.NREG(NREG), .RW(RW), .TW(TW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .rd_a    (id_src_a),
        .rd_b    (id_src_b),
        .dst_q   (id_dst),
        .wr_en   (issue && tm.writes),
        .wr_dst  (id_dst),
        .wr_fwd  (tm.fwd),
        .wr_mem  (tm.stages),
        .a_pend  (a_pend),
        .b_pend  (b_pend),
        .dst_waw (dst_waw)
    );

    fpil_port_track #(.WBW(WBW), .SW(SW)) u_port (
        .clk        (clk),
        .rst        (rst),
        .book_en    (issue && tm.writes),
        .book_slot  (SW'(tm.wb_dist)),
        .slot_taken (slot_taken)
    );

    fpil_div_track #(.TW(TW)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (issue && tm.is_div),
        .span  (tm.wb_dist),
        .busy  (div_busy)
    );

    assign src_a_ready = !id_src_a_use || !a_pend;
    assign src_b_ready = !id_src_b_use || !b_pend;

    assign struct_ok = !(tm.is_div && div_busy) && !(tm.writes && slot_taken);
    assign data_ok   = src_a_ready && src_b_ready && !(tm.writes && dst_waw);

    assign issue = id_valid && struct_ok && data_ok;
    assign stall = id_valid && !issue;

endmodule

// File: rtl/fpil_issue_chk.sv
module fpil_issue_chk
    import fpil_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int N_INT = 1,
    parameter int N_ADD = 4,
    parameter int N_MUL = 7,
    parameter int N_DIV = 24,
    localparam int RW   = $clog2(NREG)
) (
    input logic          clk,
    input logic          rst,
    input logic          id_valid,
    input logic [2:0]    id_cls,
    input logic [RW-1:0] id_src_a,
    input logic          id_src_a_use,
    input logic          id_src_b_use,
    input logic [RW-1:0] id_dst,
    input logic          issue,
    input logic          stall,
    input logic          src_a_ready,
    input logic          src_b_ready
);
    localparam int WBW = N_DIV + 3;

    op_timing_t tm;
    logic [WBW-1:0] booked;
    logic [15:0]    div_age;
    logic           div_seen;
    logic           past_ok;

    assign tm = op_timing(id_cls, N_INT, N_ADD, N_MUL, N_DIV);

    always_ff @(posedge clk) begin
        if (rst) begin
            booked   <= '0;
            div_age  <= '0;
            div_seen <= 1'b0;
            past_ok  <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            booked  <= (booked >> 1)
                     | ((issue && tm.writes) ? (WBW'(1) << (tm.wb_dist - TW'(1))) : '0);
            if (issue && tm.is_div) begin
                div_age  <= 16'd1;
                div_seen <= 1'b1;
            end else if (div_age != 16'hFFFF) begin
                div_age <= div_age + 16'd1;
            end
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !id_valid |-> (!issue && !stall)); // R2

    AST_OPERANDS_READY: assert property (@(posedge clk) disable iff (rst)
        issue |-> ((!id_src_a_use || src_a_ready) && (!id_src_b_use || src_b_ready))); // R5

    AST_ALU_FORWARD: assert property (@(posedge clk) disable iff (rst || !past_ok)
        ($past(issue && id_cls == 3'(CLS_ALU)) && id_src_a_use && id_src_a == $past(id_dst))
        |-> src_a_ready); // R3

    AST_LOAD_USE_GAP: assert property (@(posedge clk) disable iff (rst || !past_ok)
        ($past(issue && id_cls == 3'(CLS_LOAD)) && id_src_a_use && id_src_a == $past(id_dst))
        |-> !src_a_ready); // R3

    AST_PORT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (issue && tm.writes) |-> !booked[tm.wb_dist]); // R7

    AST_DIV_SPACING: assert property (@(posedge clk) disable iff (rst)
        (issue && tm.is_div && div_seen) |-> (32'(div_age) >= N_DIV + 2)); // R6

endmodule

bind fpil_issue_ctl fpil_issue_chk #(
    .NREG(NREG), .N_INT(N_INT), .N_ADD(N_ADD), .N_MUL(N_MUL), .N_DIV(N_DIV)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .id_valid     (id_valid),
    .id_cls       (id_cls),
    .id_src_a     (id_src_a),
    .id_src_a_use (id_src_a_use),
    .id_src_b_use (id_src_b_use),
    .id_dst       (id_dst),
    .issue        (issue),
    .stall        (stall),
    .src_a_ready  (src_a_ready),
    .src_b_ready  (src_b_ready)
);

// File: tb/tb_fpil_issue_ctl.sv
module tb_fpil_issue_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int C_ALU = 0, C_LOAD = 1, C_STORE = 2, C_ADD = 3, C_MUL = 4, C_DIV = 5;

    logic       clk = 0;
    logic       rst = 1;
    logic       id_valid = 0;
    logic [2:0] id_cls = 0;
    logic [4:0] id_src_a = 0, id_src_b = 0, id_dst = 0;
    logic       id_src_a_use = 0, id_src_b_use = 0;
    logic       issue, stall, src_a_ready, src_b_ready;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    int exp_q[$];
    string tag_q[$];

    int raw_at [32];
    int waw_at [32];
    bit wb_used [0:16383];
    int div_free = 0;

    fpil_issue_ctl dut (
        .clk(clk), .rst(rst), .id_valid(id_valid), .id_cls(id_cls),
        .id_src_a(id_src_a), .id_src_a_use(id_src_a_use),
        .id_src_b(id_src_b), .id_src_b_use(id_src_b_use),
        .id_dst(id_dst), .issue(issue), .stall(stall),
        .src_a_ready(src_a_ready), .src_b_ready(src_b_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    function automatic int stages_of(int c);
        case (c)
            C_ADD:   return 4;
            C_MUL:   return 7;
            C_DIV:   return 24;
            default: return 1;
        endcase
    endfunction

    function automatic int fwd_of(int c);
        return (c == C_LOAD) ? 2 : stages_of(c);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // monitor: compares each observed issue against the scoreboard
    always @(negedge clk) begin
        if (!rst && issue) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected issue", cyc, -1);
            end else begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(cyc == e, t, cyc, e);
            end
        end
    end

    task automatic send(input int c, input int sa, input bit ua, input int sb, input bit ub,
                        input int d, input string tag);
        int p, s, st;
        bit wr, ea, eb;
        @(posedge clk); #1;
        p  = cyc;
        st = stages_of(c);
        wr = (c != C_STORE);
        ea = !ua || (p >= raw_at[sa]);
        eb = !ub || (p >= raw_at[sb]);
        s  = p;
        while (!(((!ua) || s >= raw_at[sa]) && ((!ub) || s >= raw_at[sb]) &&
                 ((!wr) || s >= waw_at[d]) && (c != C_DIV || s >= div_free) &&
                 ((!wr) || !wb_used[(s + st + 2) % 16384])))
            s++;
        if (wr) begin
            raw_at[d] = s + fwd_of(c);
            waw_at[d] = s + st + 1;
            wb_used[(s + st + 2) % 16384] = 1'b1;
        end
        if (c == C_DIV) div_free = s + st + 2;
        exp_q.push_back(s);
        tag_q.push_back(tag);
        id_valid = 1; id_cls = 3'(c);
        id_src_a = 5'(sa); id_src_a_use = ua;
        id_src_b = 5'(sb); id_src_b_use = ub;
        id_dst = 5'(d);
        @(negedge clk);
        check(src_a_ready == ea, "R5 src_a_ready", int'(src_a_ready), int'(ea));
        check(src_b_ready == eb, "R5 src_b_ready", int'(src_b_ready), int'(eb));
        while (!issue) @(negedge clk);
    endtask

    task automatic hold_then_drop(input int c, input int sa, input int d, input int n);
        @(posedge clk); #1;
        id_valid = 1; id_cls = 3'(c);
        id_src_a = 5'(sa); id_src_a_use = 1;
        id_src_b = 5'(1);  id_src_b_use = 0;
        id_dst = 5'(d);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(stall == 1'b1 && issue == 1'b0, "R9 held instruction stalls",
                  int'(stall), 1);
            if (i < n - 1) @(posedge clk);
        end
    endtask

    task automatic idle(input int n);
        @(posedge clk); #1;
        id_valid = 0; id_cls = 3'd4; id_src_a_use = 1; id_src_b_use = 1;
        @(negedge clk);
        check(issue == 1'b0 && stall == 1'b0, "R2 invalid is quiet",
              int'({issue, stall}), 0);
        repeat (n - 1) @(posedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "watchdog expired", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int r = 0; r < 32; r++) begin raw_at[r] = 0; waw_at[r] = 0; end
        for (int k = 0; k < 16384; k++) wb_used[k] = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        id_src_a = 5'd3; id_src_a_use = 1; id_src_b = 5'd4; id_src_b_use = 1;
        @(negedge clk);
        // R1: empty state after reset
        check(issue == 0 && stall == 0, "R1 reset outputs quiet", int'({issue, stall}), 0);
        check(src_a_ready && src_b_ready, "R1 operands ready after reset",
              int'({src_a_ready, src_b_ready}), 3);

        send(C_ALU, 1, 1, 2, 1, 3, "R1 first issue immediate");

        // load -> multiply -> add -> store chain
        send(C_LOAD, 2, 1, 0, 0, 4, "R3 load");
        send(C_MUL, 4, 1, 6, 1, 0, "R3 multiply waits one cycle on load");
        send(C_ADD, 0, 1, 8, 1, 2, "R4 add waits on multiply");
        send(C_STORE, 2, 1, 0, 0, 0, "R4 store waits on add");
        idle(12);

        // integer forwarding
        send(C_ALU, 1, 1, 0, 0, 5, "R3 alu");
        send(C_ALU, 5, 1, 0, 0, 6, "R3 alu consumer no stall");
        send(C_LOAD, 1, 1, 0, 0, 7, "R3 load");
        send(C_ALU, 7, 1, 0, 0, 8, "R3 load consumer one stall");
        idle(5);

        // write-port clash
        send(C_MUL, 1, 1, 0, 0, 9, "R7 multiply");
        send(C_ALU, 1, 1, 0, 0, 11, "R7 alu");
        send(C_ALU, 1, 1, 0, 0, 13, "R7 alu");
        send(C_ADD, 1, 1, 0, 0, 15, "R7 add slips one slot");
        send(C_STORE, 16, 1, 0, 0, 0, "R7 store ignores port");
        idle(12);

        // divider
        send(C_DIV, 1, 1, 2, 1, 17, "R6 divide");
        send(C_DIV, 1, 1, 0, 0, 18, "R6 second divide waits");
        send(C_ADD, 18, 1, 0, 0, 19, "R4 add waits on divide");
        idle(30);

        // same-destination writers
        send(C_ADD, 1, 1, 0, 0, 20, "R8 add");
        send(C_LOAD, 1, 1, 0, 0, 20, "R8 load waits for add in memory stage");
        idle(8);
        send(C_MUL, 1, 1, 0, 0, 21, "R8 multiply");
        send(C_ALU, 1, 1, 0, 0, 21, "R8 alu waits for multiply in memory stage");
        idle(12);

        // back-to-back pipelined units
        send(C_MUL, 1, 1, 2, 1, 22, "R10 multiply");
        send(C_MUL, 1, 1, 2, 1, 23, "R10 multiply back to back");
        send(C_MUL, 1, 1, 2, 1, 24, "R10 multiply back to back");
        send(C_ADD, 1, 1, 2, 1, 25, "R7 add behind multiplies");
        idle(12);
        send(C_ADD, 1, 1, 2, 1, 25, "R10 add");
        send(C_ADD, 1, 1, 2, 1, 26, "R10 add back to back");
        idle(8);

        // unused operand
        send(C_MUL, 1, 1, 0, 0, 27, "R5 multiply");
        send(C_ALU, 1, 1, 27, 0, 28, "R5 unused pending operand ready");
        send(C_ALU, 27, 1, 0, 0, 29, "R5 used pending operand waits");
        idle(12);

        // stalled instruction withdrawn
        send(C_MUL, 20, 1, 0, 0, 10, "R9 multiply");
        hold_then_drop(C_DIV, 10, 12, 3);
        idle(1);
        send(C_ALU, 12, 1, 0, 0, 13, "R9 dropped dest not pending");
        send(C_ALU, 1, 1, 0, 0, 12, "R9 dropped dest no same-dest wait");
        send(C_DIV, 1, 1, 0, 0, 14, "R9 divider not occupied");
        idle(30);

        check(exp_q.size() == 0, "R2 all expected issues seen", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule